// File: doc/BRIEF.md
# Regulator Fault Supervisor with Crowbar

This block watches a buck regulator from the digital side. It runs on the switching clock and takes comparator flags for the analog conditions. These flags report a current-limit trip, feedback under 75 % of reference, feedback over 115 % of reference, feedback under 0.4 V, soft-start past its arming level, and two over-temperature thresholds. From these flags it decides when a switching pulse is dropped and when the converter is shut down. It also decides when the switching node is crowbarred through the low-side switch.

Three qualification counters feed one shared fault latch. Current limit and undervoltage each need a long run of consecutive cycles. Overvoltage needs only a short run, and it starts a crowbar at once, even before the latch is armed. The latch records its cause as a one-hot code. It clears when enable is dropped or when reset is applied. In auto-restart mode it also clears after a programmed number of cycles. A separate thermal shutdown with hysteresis forces both drives off without touching the latch.

Top module: `reg_fault_supervisor`

## Requirements
- R1: `skip_pulse` is high in exactly the cycles where `enable` and `ilim_trip` are both high.
- R2: With `enable` and `ss_armed` high, `ilim_trip` high on 16 consecutive sampling edges sets `fault_latched` at the 16th edge with `fault_src` = 3'b001. Fifteen trips followed by one clear cycle set nothing.
- R3: With `enable` and `ss_armed` high, `fb_under` high on 16 consecutive edges sets `fault_latched` at the 16th edge with `fault_src` = 3'b010.
- R4: With `enable` high, `fb_over` high on 2 consecutive edges starts the crowbar at the 2nd edge: `ls_on`=1, `hs_off`=1, `ls_off`=0. The crowbar ends at the first edge that samples `fb_low` high. A single overvoltage cycle starts nothing.
- R5: The crowbar acts while `ss_armed` is low. While the crowbar is active and `ss_armed` is high, the next edge sets `fault_latched` with `fault_src` = 3'b100.
- R6: No fault sets `fault_latched` while `ss_armed` is low. The current-limit and undervoltage counts are held at zero during that time.
- R7: While `fault_latched` is high and no crowbar is active, `hs_off`=1, `ls_off`=1 and `ls_on`=0.
- R8: An edge that samples `enable` low clears `fault_latched`, `fault_src` and the crowbar. Reset (`rst_n` low) clears all state.
- R9: An edge that samples `ot_hi` sets `therm_shdn`. It stays set until an edge samples `ot_ok` with `ot_hi` low. While it is set, `hs_off`=1 and `ls_off`=1 unless a crowbar is active.
- R10: With `auto_mode`=1 and a latch set at edge E, `restart_req` is high during the cycle after edge E+`restart_delay`. The latch clears at the next edge. With `auto_mode`=0 the latch stays set until `enable` drops.
- R11: If several sources qualify on the same edge, `fault_src` takes the highest of overvoltage, then current limit, then undervoltage. The code is held unchanged while latched and is zero when not latched.
- R12: A qualification counter returns to zero on any cycle without its condition and saturates rather than wrapping. A condition that persists through an auto-restart therefore re-sets the latch at the edge after it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Active-low reset, models a supply recycle |
| enable | input | 1 | Regulator enable |
| ss_armed | input | 1 | Soft-start has passed the protection arming level |
| ilim_trip | input | 1 | Current-limit comparator tripped this cycle |
| fb_under | input | 1 | Feedback below 75 % of reference |
| fb_over | input | 1 | Feedback above 115 % of reference |
| fb_low | input | 1 | Feedback below 0.4 V |
| ot_hi | input | 1 | Die temperature above the shutdown threshold |
| ot_ok | input | 1 | Die temperature at or below the recovery threshold |
| auto_mode | input | 1 | 1 selects auto-restart, 0 selects latched-off |
| restart_delay | input | DELAY_W | Restart delay in clock cycles |
| fault_latched | output | 1 | Fault latch state |
| fault_src | output | 3 | One-hot cause: bit0 current limit, bit1 undervoltage, bit2 overvoltage |
| skip_pulse | output | 1 | Drop this cycle's switching pulse |
| hs_off | output | 1 | Force high-side drive off |
| ls_off | output | 1 | Force low-side drive off |
| ls_on | output | 1 | Force low-side drive on (crowbar) |
| restart_req | output | 1 | Auto-restart fires this cycle |
| therm_shdn | output | 1 | Thermal shutdown active |

## Verification
The hardest case to reach is a fault that persists across an auto-restart. It needs the latch set in auto mode, the delay to elapse, and the condition still present, so that the saturated counter re-fires at the edge after the clear. A crowbar that starts before arming and only latches once `ss_armed` rises is also rare under random input. The stimulus holds undervoltage through a short programmed delay, and it raises `fb_over` with `ss_armed` low before arming by hand. Biased random phases with sticky soft-start and rare enable drops then mix these states with thermal events.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  localparam int SRC_OCP = 0;
  localparam int SRC_UVP = 1;
  localparam int SRC_OVP = 2;
  localparam int SRC_N   = 3;

  typedef logic [SRC_N-1:0] fault_src_t;

  // Priority encoder for the fault cause: overvoltage, current limit, undervoltage.
  function automatic fault_src_t pick_source(input logic ovp, input logic ocp,
                                             input logic uvp);
    fault_src_t s;
    s = '0;
    if (ovp)      s[SRC_OVP] = 1'b1;
    else if (ocp) s[SRC_OCP] = 1'b1;
    else if (uvp) s[SRC_UVP] = 1'b1;
    return s;
  endfunction

  // Saturating increment toward a ceiling.
  function automatic int unsigned sat_step(input int unsigned v, input int unsigned top);
    return (v >= top) ? top : v + 1;
  endfunction

endpackage

// File: rtl/rfs_persist_cnt.sv
module rfs_persist_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cond,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign hit = cond && !clr && (cnt >= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr || !cond)   cnt <= '0;
    else if (cnt < LAST)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfs_crowbar.sv
module rfs_crowbar (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ovp_hit,
  input  logic fb_low,
  output logic active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 active <= 1'b0;
    else if (!enable)           active <= 1'b0;
    else if (active && fb_low)  active <= 1'b0;
    else if (ovp_hit && !fb_low) active <= 1'b1;
  end
endmodule

// File: rtl/rfs_fault_latch.sv
module rfs_fault_latch
  import rfs_pkg::*;
#(
  parameter int DELAY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               ss_armed,
  input  logic               ocp_hit,
  input  logic               uvp_hit,
  input  logic               crowbar,
  input  logic               auto_mode,
  input  logic [DELAY_W-1:0] restart_delay,
  output logic               latched,
  output fault_src_t         src,
  output logic               restart_fire
);
  logic [DELAY_W-1:0] tmr;
  logic               set_req;
  logic               clr_req;

  assign restart_fire = latched && auto_mode && (tmr >= restart_delay);
  assign clr_req      = !enable || restart_fire;
  assign set_req      = enable && ss_armed && !latched && (crowbar || ocp_hit || uvp_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched <= 1'b0;
      src     <= '0;
    end else if (clr_req) begin
      latched <= 1'b0;
      src     <= '0;
    end else if (set_req) begin
      latched <= 1'b1;
      src     <= pick_source(crowbar, ocp_hit, uvp_hit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tmr <= '0;
    else if (!latched)   tmr <= '0;
    else if (~&tmr)      tmr <= tmr + 1'b1;
  end
endmodule

// File: rtl/rfs_gate_ctl.sv
module rfs_gate_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ilim_trip,
  input  logic ot_hi,
  input  logic ot_ok,
  input  logic latched,
  input  logic crowbar,
  output logic therm_shdn,
  output logic skip_pulse,
  output logic hs_off,
  output logic ls_off,
  output logic ls_on
);
  logic shut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      therm_shdn <= 1'b0;
    else if (ot_hi)  therm_shdn <= 1'b1;
    else if (ot_ok)  therm_shdn <= 1'b0;
  end

  assign shut       = !enable || latched || therm_shdn;
  assign skip_pulse = enable && ilim_trip;
  assign hs_off     = shut || crowbar;
  assign ls_on      = crowbar;
  assign ls_off     = shut && !crowbar;
endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor
  import rfs_pkg::*;
#(
  parameter int OCP_CYCLES = 16,
  parameter int UVP_CYCLES = 16,
  parameter int OVP_CYCLES = 2,
  parameter int DELAY_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               ss_armed,
  input  logic               ilim_trip,
  input  logic               fb_under,
  input  logic               fb_over,
  input  logic               fb_low,
  input  logic               ot_hi,
  input  logic               ot_ok,
  input  logic               auto_mode,
  input  logic [DELAY_W-1:0] restart_delay,
  output logic               fault_latched,
  output logic [2:0]         fault_src,
  output logic               skip_pulse,
  output logic               hs_off,
  output logic               ls_off,
  output logic               ls_on,
  output logic               restart_req,
  output logic               therm_shdn
);
  logic [SRC_N-1:0] cond_v;
  logic [SRC_N-1:0] clr_v;
  logic [SRC_N-1:0] hit_v;
  logic             crowbar;
  fault_src_t       src_q;

  assign cond_v[SRC_OCP] = ilim_trip;
  assign cond_v[SRC_UVP] = fb_under;
  assign cond_v[SRC_OVP] = fb_over;
  // Overload and undervoltage only count once armed; overvoltage counts from enable.
  assign clr_v[SRC_OCP]  = !enable || !ss_armed;
  assign clr_v[SRC_UVP]  = !enable || !ss_armed;
  assign clr_v[SRC_OVP]  = !enable;

  for (genvar g = 0; g < SRC_N; g++) begin : g_qual
    localparam int LIM = (g == SRC_OCP) ? OCP_CYCLES :
                         (g == SRC_UVP) ? UVP_CYCLES : OVP_CYCLES;
    rfs_persist_cnt #(.LIMIT(LIM)) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_v[g]),
      .cond  (cond_v[g]),
      .hit   (hit_v[g])
    );
  end

  rfs_crowbar cb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .ovp_hit (hit_v[SRC_OVP]),
    .fb_low  (fb_low),
    .active  (crowbar)
  );

  rfs_fault_latch #(.DELAY_W(DELAY_W)) fl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .ss_armed      (ss_armed),
    .ocp_hit       (hit_v[SRC_OCP]),
    .uvp_hit       (hit_v[SRC_UVP]),
    .crowbar       (crowbar),
    .auto_mode     (auto_mode),
    .restart_delay (restart_delay),
    .latched       (fault_latched),
    .src           (src_q),
    .restart_fire  (restart_req)
  );

  assign fault_src = src_q;

  rfs_gate_ctl gc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .ilim_trip  (ilim_trip),
    .ot_hi      (ot_hi),
    .ot_ok      (ot_ok),
    .latched    (fault_latched),
    .crowbar    (crowbar),
    .therm_shdn (therm_shdn),
    .skip_pulse (skip_pulse),
    .hs_off     (hs_off),
    .ls_off     (ls_off),
    .ls_on      (ls_on)
  );
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       ss_armed,
  input logic       fb_over,
  input logic       ot_hi,
  input logic       fault_latched,
  input logic [2:0] fault_src,
  input logic       hs_off,
  input logic       ls_off,
  input logic       ls_on,
  input logic       restart_req,
  input logic       therm_shdn
);
  assert_crowbar_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ls_on |-> (hs_off && !ls_off));

  assert_crowbar_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> ($past(fb_over) && $past(fb_over, 2)));

  assert_armed_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> ($past(ss_armed) && $past(enable)));

  assert_latched_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && !ls_on) |-> (hs_off && ls_off));

  assert_enable_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!fault_latched && !ls_on));

  assert_thermal_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ot_hi |=> (therm_shdn && hs_off));

  assert_restart_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !fault_latched);

  assert_src_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> ($countones(fault_src) == 1));

  assert_src_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_latched |-> (fault_src == 3'b000));

  assert_src_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && $past(fault_latched)) |-> $stable(fault_src));
endmodule

bind reg_fault_supervisor rfs_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .ss_armed      (ss_armed),
  .fb_over       (fb_over),
  .ot_hi         (ot_hi),
  .fault_latched (fault_latched),
  .fault_src     (fault_src),
  .hs_off        (hs_off),
  .ls_off        (ls_off),
  .ls_on         (ls_on),
  .restart_req   (restart_req),
  .therm_shdn    (therm_shdn)
);

// File: tb/reg_fault_supervisor_tb.sv
module reg_fault_supervisor_tb_top;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, ss = 0, ilim = 0, fbu = 0, fbo = 0, fbl = 0, othi = 0, otok = 0, amode = 0;
  logic [DW-1:0] dly = '0;

  logic fault_latched, skip_pulse, hs_off, ls_off, ls_on, restart_req, therm_shdn;
  logic [2:0] fault_src;

  int n_tests = 0;
  int n_fail  = 0;

  // reference state
  int  m_ocp = 0, m_uvp = 0, m_ovp = 0, m_tmr = 0;
  bit  m_cb = 0, m_lat = 0, m_th = 0;
  bit [2:0] m_src = 0;

  always #2 clk = ~clk;

  reg_fault_supervisor #(.DELAY_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(en), .ss_armed(ss), .ilim_trip(ilim),
    .fb_under(fbu), .fb_over(fbo), .fb_low(fbl), .ot_hi(othi), .ot_ok(otok),
    .auto_mode(amode), .restart_delay(dly), .fault_latched(fault_latched),
    .fault_src(fault_src), .skip_pulse(skip_pulse), .hs_off(hs_off),
    .ls_off(ls_off), .ls_on(ls_on), .restart_req(restart_req), .therm_shdn(therm_shdn)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit fires(input int cnt, input int lim, input bit cond);
    return cond && (cnt + 1 >= lim);
  endfunction

  function automatic int bump(input int cnt, input int lim, input bit cond, input bit hold0);
    if (hold0 || !cond) return 0;
    return (cnt + 1 >= lim) ? lim - 1 : cnt + 1;
  endfunction

  function automatic bit restart_now();
    return m_lat && amode && (m_tmr >= int'(dly));
  endfunction

  // Advance the reference model by one edge using the inputs currently applied.
  task automatic model_edge();
    bit armed_ok, oc, uv, ov, clr, setr;
    bit [2:0] s;
    armed_ok = en && ss;
    oc  = armed_ok && fires(m_ocp, 16, ilim);
    uv  = armed_ok && fires(m_uvp, 16, fbu);
    ov  = en && fires(m_ovp, 2, fbo);
    clr  = !en || restart_now();
    setr = armed_ok && !m_lat && (m_cb || oc || uv);
    s = m_cb ? 3'b100 : oc ? 3'b001 : uv ? 3'b010 : 3'b000;
    m_tmr = m_lat ? ((m_tmr >= 65535) ? 65535 : m_tmr + 1) : 0;
    if (clr) begin m_lat = 0; m_src = 0; end
    else if (setr) begin m_lat = 1; m_src = s; end
    if (!en) m_cb = 0;
    else if (m_cb && fbl) m_cb = 0;
    else if (ov && !fbl) m_cb = 1;
    m_ocp = bump(m_ocp, 16, ilim, !armed_ok);
    m_uvp = bump(m_uvp, 16, fbu, !armed_ok);
    m_ovp = bump(m_ovp, 2, fbo, !en);
    if (othi) m_th = 1; else if (otok) m_th = 0;
  endtask

  task automatic compare_all();
    bit shut;
    shut = !en || m_lat || m_th;
    check("R1",  "skip_pulse",   skip_pulse, en && ilim);
    check("R8",  "fault_latched", fault_latched, m_lat);
    check("R11", "fault_src",    fault_src, m_src);
    check("R4",  "ls_on",        ls_on, m_cb);
    check("R7",  "hs_off",       hs_off, shut || m_cb);
    check("R7",  "ls_off",       ls_off, shut && !m_cb);
    check("R10", "restart_req",  restart_req, restart_now());
    check("R9",  "therm_shdn",   therm_shdn, m_th);
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic idle_inputs();
    ilim = 0; fbu = 0; fbo = 0; fbl = 0; othi = 0; otok = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7315));
    repeat (3) @(posedge clk);
    #1;
    check("R8", "reset fault_latched", fault_latched, 0);
    check("R8", "reset fault_src", fault_src, 0);
    check("R4", "reset ls_on", ls_on, 0);
    rst_n = 1'b1;
    step();

    // R2: 15 trips then a gap, then 16 trips
    en = 1; ss = 1; ilim = 1;
    steps(15);
    check("R2", "15 trips no latch", fault_latched, 0);
    ilim = 0; step();
    ilim = 1; steps(15);
    check("R12", "counter restarted after gap", fault_latched, 0);
    step();
    check("R2", "16 trips latch", fault_latched, 1);
    check("R2", "ocp source", fault_src, 3'b001);
    ilim = 0; steps(20);
    check("R10", "latched mode holds", fault_latched, 1);
    check("R7", "latched hs_off", hs_off, 1);
    check("R7", "latched ls_off", ls_off, 1);
    en = 0; step();
    check("R8", "enable low clears", fault_latched, 0);
    check("R8", "enable low clears src", fault_src, 0);

    // R6 + R4 + R5: crowbar before arming
    en = 1; ss = 0; fbu = 1; steps(30);
    check("R6", "undervoltage unarmed", fault_latched, 0);
    fbu = 0; fbo = 1; step();
    check("R4", "one OV cycle no crowbar", ls_on, 0);
    fbo = 0; step();
    fbo = 1; steps(2);
    check("R4", "crowbar on", ls_on, 1);
    check("R4", "crowbar hs off", hs_off, 1);
    check("R5", "crowbar unarmed no latch", fault_latched, 0);
    fbo = 0; steps(3);
    check("R4", "crowbar persists", ls_on, 1);
    ss = 1; step();
    check("R5", "ovp latch", fault_latched, 1);
    check("R5", "ovp source", fault_src, 3'b100);
    check("R7", "crowbar overrides latched ls", ls_off, 0);
    fbl = 1; step();
    check("R4", "fb_low ends crowbar", ls_on, 0);
    check("R7", "latched both off", ls_off, 1);
    fbl = 0; en = 0; step();

    // R11: simultaneous current limit and undervoltage
    en = 1; ss = 1; ilim = 1; fbu = 1; steps(16);
    check("R11", "priority ocp over uvp", fault_src, 3'b001);
    idle_inputs(); en = 0; step();

    // R3 + R10 + R12: auto restart with persisting undervoltage
    en = 1; amode = 1; dly = 16'd5; fbu = 1; steps(16);
    check("R3", "uvp latch", fault_latched, 1);
    check("R3", "uvp source", fault_src, 3'b010);
    steps(5);
    check("R10", "restart_req after delay", restart_req, 1);
    step();
    check("R10", "restart clears latch", fault_latched, 0);
    step();
    check("R12", "saturated counter re-latches", fault_latched, 1);
    fbu = 0; en = 0; step(); amode = 0; en = 1; step();

    // R9: thermal hysteresis
    othi = 1; step(); othi = 0;
    check("R9", "thermal set", therm_shdn, 1);
    steps(4);
    check("R9", "thermal held", therm_shdn, 1);
    check("R9", "thermal gates off", ls_off, 1);
    otok = 1; step(); otok = 0;
    check("R9", "thermal cleared", therm_shdn, 0);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      int r;
      r = $urandom_range(0, 999);
      if (r < 4) en = ~en;
      if (!en) ss = 0; else if ($urandom_range(0, 99) < 3) ss = 1;
      if ($urandom_range(0, 199) == 0) ss = 0;
      ilim  = ($urandom_range(0, 99) < (c % 400 < 200 ? 92 : 20));
      fbu   = ($urandom_range(0, 99) < (c % 300 < 100 ? 95 : 10));
      fbo   = ($urandom_range(0, 99) < 25);
      fbl   = ($urandom_range(0, 99) < 8);
      othi  = ($urandom_range(0, 499) == 0);
      otok  = ($urandom_range(0, 49) == 0);
      if ($urandom_range(0, 99) == 0) amode = ~amode;
      if ($urandom_range(0, 99) == 0) dly = DW'($urandom_range(0, 12));
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule